// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block decides the operating state of a single-wire bus transceiver that also has a supply regulator. It watches three sampled control pins (enable, standby and transmit data). It also takes event pulses from neighbouring blocks: local wake, bus wake and supply undervoltage. From these it selects one of four states: standby, sleep, full-speed transmission or reduced-slew transmission. The outputs from the state drive the regulator, the transmitter, the slope shaping, the bus termination, the auxiliary inhibit output and the source of the receive-data pin.

Two extra protections act on the transmitter:
- A dominant timeout switches the transmitter off when transmit data stays low for too long. The transmitter comes back once transmit data returns high.
- A thermal-shutdown flag forces the transmitter off at once.

While the reset generator reports that inputs are blocked, the control pins cannot change the state. All durations are parameters counted in clock cycles. The interface is control only. There is no data stream and so no back-pressure.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After reset the block is in standby: `reg_en`=1, `tx_en`=0, `term_en`=0, `slope_low`=0, `inh_drive`=0, `rxd_sel`=1 (recessive).
- R2: In standby, a rising edge on `en_pin` while `txd_pin`=1 selects full-speed mode on the next clock: `term_en`=1, `slope_low`=0, `tx_en`=1, `rxd_sel`=0 (bus data).
- R3: In standby, a rising edge on `en_pin` while `txd_pin`=0 selects reduced-slew mode: `slope_low`=1, `term_en`=1. `tx_en` stays 0 until `txd_pin` is first seen high. After that, `tx_en` stays 1 when `txd_pin` goes low again, until the timeout.
- R4: `inh_drive` takes the value of `stb_pin` at the edge that enters either transmitting mode. It keeps that value while the block is in the mode, and returns to 0 when the block leaves the mode.
- R5: In either transmitting mode, a falling edge on `en_pin` goes to standby when `stb_pin`=1. It goes to sleep when `stb_pin`=0. In sleep, `reg_en`=0, `tx_en`=0, `term_en`=0, `inh_drive`=0 and `rxd_sel`=1.
- R6: In sleep, a `wake_local` pulse moves the block to standby with `rxd_sel`=1. A `wake_remote` pulse moves it to standby with `rxd_sel`=2 (wake flag).
- R7: A `wake_remote` pulse in standby sets `rxd_sel`=2. The flag clears when a transmitting mode is entered.
- R8: A `uv_evt` pulse in a transmitting mode forces standby on the next clock.
- R9: When `txd_pin` is low for DOM_CYCLES consecutive clocks in a transmitting mode, `tx_en` drops to 0. The first clock that samples `txd_pin`=1 re-enables it.
- R10: `tsd_flag`=1 forces `tx_en`=0 in the same cycle, with no clock needed.
- R11: While `inputs_blocked`=1, edges on `en_pin` cause no mode change. An enable that rose while blocked does not act once the blocking ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| en_pin | input | 1 | Sampled enable control pin |
| stb_pin | input | 1 | Sampled standby control pin |
| txd_pin | input | 1 | Sampled transmit data, 0 = dominant |
| wake_local | input | 1 | One-cycle local wake event |
| wake_remote | input | 1 | One-cycle bus wake event |
| uv_evt | input | 1 | One-cycle supply undervoltage event |
| inputs_blocked | input | 1 | Reset generator holds control pins ignored |
| tsd_flag | input | 1 | Thermal shutdown active |
| reg_en | output | 1 | Regulator on |
| tx_en | output | 1 | Transmitter driver allowed |
| slope_low | output | 1 | Reduced slew rate selected |
| term_en | output | 1 | Termination resistor connected |
| inh_drive | output | 1 | Inhibit output driven high (else floating) |
| rxd_sel | output | 2 | Receive pin source: 0 bus, 1 recessive, 2 wake flag |

## Verification
The hardest case to reach is the reduced-slew mode, where three gates stack on the transmitter: the arming that waits for the first high transmit bit, the dominant timeout and the thermal flag. The bench enters reduced-slew mode with transmit data low. It holds the data low for a few cycles to show that the gate stays off, then releases it to arm the driver. It then drives a long dominant run, and counts clocks around the timeout limit so that the drop and the recovery are each seen at a known cycle. The blocking case is also delicate. The enable edge is raised under blocking and still held high after the blocking ends, which shows that a stale edge is not replayed.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;
  typedef enum logic [1:0] {
    MD_SLEEP = 2'd0,
    MD_STBY  = 2'd1,
    MD_FAST  = 2'd2,
    MD_SLOW  = 2'd3
  } op_mode_t;

  localparam logic [1:0] RXSRC_BUS  = 2'd0;
  localparam logic [1:0] RXSRC_REC  = 2'd1;
  localparam logic [1:0] RXSRC_WAKE = 2'd2;
endpackage

// File: rtl/lmc_pin_edges.sv
module lmc_pin_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
  assign fall_o = ~level_i & level_q;
endmodule

// File: rtl/lmc_dom_timer.sv
module lmc_dom_timer #(
  parameter int unsigned DOM_CYCLES = 1_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic txd_i,
  output logic lock_o
);
  localparam int unsigned CW = $clog2(DOM_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DOM_CYCLES - 1);

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      lock_o  <= 1'b0;
    end else if (!active_i || txd_i) begin
      run_cnt <= '0;
      lock_o  <= 1'b0;
    end else if (!lock_o) begin
      run_cnt <= run_cnt + 1'b1;
      if (run_cnt == LAST) lock_o <= 1'b1;
    end
  end
endmodule

// File: rtl/lmc_mode_fsm.sv
module lmc_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_rise_i,
  input  logic     en_fall_i,
  input  logic     stb_i,
  input  logic     txd_i,
  input  logic     wake_local_i,
  input  logic     wake_remote_i,
  input  logic     uv_i,
  input  logic     blocked_i,
  output op_mode_t mode_o,
  output logic     inh_o,
  output logic     armed_o,
  output logic     wake_flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_o      <= MD_STBY;
      inh_o       <= 1'b0;
      armed_o     <= 1'b0;
      wake_flag_o <= 1'b0;
    end else begin
      case (mode_o)
        MD_SLEEP: begin
          if (wake_local_i || wake_remote_i) begin
            mode_o      <= MD_STBY;
            wake_flag_o <= wake_remote_i;
          end
        end
        MD_STBY: begin
          if (wake_remote_i) wake_flag_o <= 1'b1;
          if (en_rise_i && !blocked_i) begin
            mode_o      <= txd_i ? MD_FAST : MD_SLOW;
            inh_o       <= stb_i;
            armed_o     <= txd_i;
            wake_flag_o <= 1'b0;
          end
        end
        default: begin
          if (uv_i) begin
            mode_o  <= MD_STBY;
            inh_o   <= 1'b0;
            armed_o <= 1'b0;
          end else if (en_fall_i && !blocked_i) begin
            mode_o  <= stb_i ? MD_STBY : MD_SLEEP;
            inh_o   <= 1'b0;
            armed_o <= 1'b0;
          end else if (txd_i && !blocked_i) begin
            armed_o <= 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl
  import lin_mode_pkg::*;
#(
  parameter int unsigned DOM_CYCLES = 1_000_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_pin,
  input  logic       stb_pin,
  input  logic       txd_pin,
  input  logic       wake_local,
  input  logic       wake_remote,
  input  logic       uv_evt,
  input  logic       inputs_blocked,
  input  logic       tsd_flag,
  output logic       reg_en,
  output logic       tx_en,
  output logic       slope_low,
  output logic       term_en,
  output logic       inh_drive,
  output logic [1:0] rxd_sel
);
  logic     en_rise, en_fall;
  op_mode_t mode;
  logic     armed, wake_flag, dom_lock, active;

  lmc_pin_edges u_edges (
    .clk(clk), .rst_n(rst_n), .level_i(en_pin),
    .rise_o(en_rise), .fall_o(en_fall)
  );

  lmc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .en_rise_i(en_rise), .en_fall_i(en_fall),
    .stb_i(stb_pin), .txd_i(txd_pin),
    .wake_local_i(wake_local), .wake_remote_i(wake_remote),
    .uv_i(uv_evt), .blocked_i(inputs_blocked),
    .mode_o(mode), .inh_o(inh_drive), .armed_o(armed),
    .wake_flag_o(wake_flag)
  );

  assign active = (mode == MD_FAST) || (mode == MD_SLOW);

  lmc_dom_timer #(.DOM_CYCLES(DOM_CYCLES)) u_dom (
    .clk(clk), .rst_n(rst_n), .active_i(active),
    .txd_i(txd_pin), .lock_o(dom_lock)
  );

  always_comb begin
    reg_en    = (mode != MD_SLEEP);
    term_en   = active;
    slope_low = (mode == MD_SLOW);
    tx_en     = active && armed && !dom_lock && !tsd_flag;
    if (active)                          rxd_sel = RXSRC_BUS;
    else if (mode == MD_STBY && wake_flag) rxd_sel = RXSRC_WAKE;
    else                                 rxd_sel = RXSRC_REC;
  end
endmodule

// File: rtl/lin_mode_ctrl_chk.sv
module lin_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       uv_evt,
  input logic       inputs_blocked,
  input logic       tsd_flag,
  input logic       reg_en,
  input logic       tx_en,
  input logic       slope_low,
  input logic       term_en,
  input logic       inh_drive,
  input logic [1:0] rxd_sel
);
  // R10
  tsd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tsd_flag |-> !tx_en);

  // R5
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_en |-> (!tx_en && !term_en && !inh_drive && rxd_sel == 2'd1));

  // R8
  uv_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_evt && term_en) |=> (!term_en && reg_en));

  // R11
  blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inputs_blocked && reg_en && !term_en) |=> !term_en);

  // R4
  inh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (term_en && $past(term_en)) |-> $stable(inh_drive));

  // R3
  slow_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slope_low |-> (term_en && rxd_sel == 2'd0));
endmodule

bind lin_mode_ctrl lin_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .uv_evt(uv_evt),
  .inputs_blocked(inputs_blocked), .tsd_flag(tsd_flag),
  .reg_en(reg_en), .tx_en(tx_en), .slope_low(slope_low),
  .term_en(term_en), .inh_drive(inh_drive), .rxd_sel(rxd_sel)
);

// File: tb/lin_mode_ctrl_test.sv
`timescale 1ns/1ps
module lin_mode_ctrl_test;
  localparam int unsigned DOM = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin = 0, stb_pin = 0, txd_pin = 1;
  logic wake_local = 0, wake_remote = 0, uv_evt = 0, inputs_blocked = 0, tsd_flag = 0;
  logic reg_en, tx_en, slope_low, term_en, inh_drive;
  logic [1:0] rxd_sel;

  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  lin_mode_ctrl #(.DOM_CYCLES(DOM)) uut (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .stb_pin(stb_pin),
    .txd_pin(txd_pin), .wake_local(wake_local), .wake_remote(wake_remote),
    .uv_evt(uv_evt), .inputs_blocked(inputs_blocked), .tsd_flag(tsd_flag),
    .reg_en(reg_en), .tx_en(tx_en), .slope_low(slope_low), .term_en(term_en),
    .inh_drive(inh_drive), .rxd_sel(rxd_sel)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1; step(1); sig = 1'b0;
  endtask

  task automatic enter(input logic txd, input logic stb);
    txd_pin = txd; stb_pin = stb; en_pin = 1'b1; step(1);
  endtask

  task automatic leave(input logic stb);
    txd_pin = 1'b1; stb_pin = stb; en_pin = 1'b0; step(1);
  endtask

  task automatic t_reset();
    chk("R1", "reg_en", reg_en, 1);
    chk("R1", "tx_en", tx_en, 0);
    chk("R1", "term_en", term_en, 0);
    chk("R1", "slope_low", slope_low, 0);
    chk("R1", "inh", inh_drive, 0);
    chk("R1", "rxd_sel", rxd_sel, 1);
  endtask

  task automatic t_fast();
    enter(1'b1, 1'b1);
    chk("R2", "term_en", term_en, 1);
    chk("R2", "slope_low", slope_low, 0);
    chk("R2", "tx_en", tx_en, 1);
    chk("R2", "rxd_sel", rxd_sel, 0);
    chk("R4", "inh latched high", inh_drive, 1);
    stb_pin = 1'b0; step(2);
    chk("R4", "inh held after stb low", inh_drive, 1);
    leave(1'b1);
    chk("R5", "standby term_en", term_en, 0);
    chk("R5", "standby reg_en", reg_en, 1);
    chk("R4", "inh cleared on exit", inh_drive, 0);
  endtask

  task automatic t_slow_and_timeout();
    enter(1'b0, 1'b0);
    chk("R3", "slope_low", slope_low, 1);
    chk("R4", "inh floats", inh_drive, 0);
    chk("R3", "tx gated at entry", tx_en, 0);
    step(3);
    chk("R3", "tx still gated", tx_en, 0);
    txd_pin = 1'b1; step(1);
    chk("R3", "tx armed", tx_en, 1);
    txd_pin = 1'b0; step(DOM - 1);
    chk("R9", "tx before limit", tx_en, 1);
    step(2);
    chk("R9", "tx after limit", tx_en, 0);
    txd_pin = 1'b1; step(1);
    chk("R9", "tx restored", tx_en, 1);
    tsd_flag = 1'b1; #1;
    chk("R10", "tx under tsd", tx_en, 0);
    tsd_flag = 1'b0; #1;
    chk("R10", "tx after tsd", tx_en, 1);
    leave(1'b0);
    chk("R5", "sleep reg_en", reg_en, 0);
    chk("R5", "sleep rxd_sel", rxd_sel, 1);
  endtask

  task automatic t_wake();
    pulse(wake_local);
    chk("R6", "local wake reg_en", reg_en, 1);
    chk("R6", "local wake rxd_sel", rxd_sel, 1);
    enter(1'b1, 1'b0);
    leave(1'b0);
    chk("R5", "sleep again", reg_en, 0);
    pulse(wake_remote);
    chk("R6", "remote wake reg_en", reg_en, 1);
    chk("R6", "remote wake rxd_sel", rxd_sel, 2);
    enter(1'b1, 1'b0);
    chk("R7", "flag hidden in normal", rxd_sel, 0);
    leave(1'b1);
    chk("R7", "flag cleared", rxd_sel, 1);
    pulse(wake_remote);
    chk("R7", "standby bus wake", rxd_sel, 2);
  endtask

  task automatic t_uv();
    enter(1'b1, 1'b1);
    chk("R8", "in normal", term_en, 1);
    pulse(uv_evt);
    chk("R8", "uv term_en", term_en, 0);
    chk("R8", "uv reg_en", reg_en, 1);
    chk("R8", "uv inh", inh_drive, 0);
    en_pin = 1'b0; step(1);
    chk("R8", "stays standby", reg_en, 1);
  endtask

  task automatic t_blocked();
    inputs_blocked = 1'b1; txd_pin = 1'b1; en_pin = 1'b1; step(2);
    chk("R11", "blocked term_en", term_en, 0);
    inputs_blocked = 1'b0; step(2);
    chk("R11", "stale edge term_en", term_en, 0);
    en_pin = 1'b0; step(1);
    enter(1'b1, 1'b0);
    chk("R11", "fresh edge works", term_en, 1);
    inputs_blocked = 1'b1; en_pin = 1'b0; step(2);
    chk("R11", "fall ignored", term_en, 1);
    inputs_blocked = 1'b0; step(1);
  endtask

  initial begin
    step(2);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_fast();
    t_slow_and_timeout();
    t_wake();
    t_uv();
    t_blocked();
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule